// File: doc/BRIEF.md
# Address-Latched Single-Bit RAM with Output Gating

This block is a 256-location memory, one bit wide, with three active-low enables and a clock-synchronous model of a tri-state data pin. One enable acts as a strobe. An access opens only when the strobe goes from high to low between two samples. At that same clock edge, an internal register captures the 8-bit address. The address input is then ignored until the next falling strobe.

While the access is open and the strobe stays low, the write-enable input chooses the operation:
- With write-enable low, each clock edge writes the data-in bit into the latched location, and the output is switched off.
- With write-enable high, the stored bit appears on the output after a fixed number of cycles. It appears only while the other two enables are both low.

Those two enables only gate the output. A bused system can turn the pin off and on again without closing the access or re-strobing. Driving the strobe high closes the access. The data-out value paired with its enable flag stands in for the tri-state pin: when the flag is low, the pin is undriven. Memory contents are not cleared by reset. Reset clears only the address latch and the control state.

Top module: `latched_bit_ram`

## Requirements
- R1: After reset, `selected` and `dataOutEn` are 0 and `dataOut` is 0.
- R2: An access opens, with `selected` going to 1, only at a clock edge where `strobeN` is sampled 0 and was sampled 1 at the previous edge. A strobe held low through reset and afterwards opens no access and writes nothing.
- R3: The address is captured at the opening edge. Changes on `addr` while the access is open do not change which location is read or written.
- R4: At each clock edge after the opening edge where the access is open and both `strobeN` and `writeN` are sampled 0, `dataIn` is stored at the latched address. `gateAN` and `gateBN` have no effect on the write.
- R5: After any edge where `writeN` is sampled 0, `dataOutEn` is 0.
- R6: With `writeN` high and both gates low, `dataOutEn` becomes 1 exactly READ_LAT clock edges after the opening edge (READ_LAT=2 by default). `dataOut` then equals the bit stored at the latched address.
- R7: After an edge where `gateAN` or `gateBN` is sampled 1, `dataOutEn` is 0 while `selected` stays 1. Returning both gates low restores the output at the next edge, with no new strobe edge.
- R8: At an edge where `strobeN` is sampled 1, the access closes: `selected` and `dataOutEn` are 0 afterwards.
- R9: `dataOut` is 0 whenever `dataOutEn` is 0.
- R10: Each new opening edge restarts the read latency. The output stays off for READ_LAT edges after it, even if the previous access had the output on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of latch and control state |
| strobeN | input | 1 | Active-low strobe enable; its falling sample opens an access and latches the address |
| gateAN | input | 1 | Active-low output gate A; high turns the output off |
| gateBN | input | 1 | Active-low output gate B; high turns the output off |
| writeN | input | 1 | Active-low write enable |
| addr | input | ADDR_W (8) | Location address, captured at the opening edge |
| dataIn | input | 1 | Bit to store on a write |
| dataOut | output | 1 | Read bit, 0 when not driven |
| dataOutEn | output | 1 | High when the modelled tri-state pin is driven |
| selected | output | 1 | High while an access is open |

## Verification
A wrong address latch shows up as a read returning the bit of a different location. The mismatch appears at the first enabled output after the access opens, or one access later when a write has gone to the wrong cell. A faulty edge detector or selection state shows up at once on `selected`: it rises under a held-low strobe, or stays high after the strobe returns high. A faulty latency counter or gate sampling shows up as `dataOutEn` rising one edge early or late, or staying on after a gate or write-enable change.

// File: rtl/latched_bit_ram_pkg.sv
package latched_bit_ram_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the address this edge
    logic wrEn;     // store dataIn this edge
    logic drive;    // output pin driven
  } ctrlStrobes_t;

endpackage

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import latched_bit_ram_pkg::*;
#(
  parameter int READ_LAT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         strobeN,
  input  logic         gateAN,
  input  logic         gateBN,
  input  logic         writeN,
  output ctrlStrobes_t strobes,
  output logic         selected
);

  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(READ_LAT);

  logic             strobePrev;
  logic             fallSeen;
  logic [CNT_W-1:0] latCnt;
  logic             wrHighS;
  logic             gatesLowS;

  // previous sample high, current low; prev is 0 after reset so a held strobe is inert
  assign fallSeen = strobePrev & ~strobeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      selected   <= 1'b0;
      latCnt     <= '0;
      wrHighS    <= 1'b0;
      gatesLowS  <= 1'b0;
    end else begin
      strobePrev <= strobeN;
      wrHighS    <= writeN;
      gatesLowS  <= ~gateAN & ~gateBN;
      if (fallSeen) begin
        selected <= 1'b1;
        latCnt   <= '0;
      end else if (strobeN) begin
        selected <= 1'b0;
        latCnt   <= '0;
      end else if (selected && latCnt != CNT_DONE) begin
        latCnt <= latCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobes.capture = fallSeen;
    strobes.wrEn    = selected & ~strobeN & ~writeN;
    strobes.drive   = selected & (latCnt == CNT_DONE) & wrHighS & gatesLowS;
  end

endmodule

// File: rtl/lbr_datapath.sv
module lbr_datapath
  import latched_bit_ram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrLatch;
  logic [DEPTH-1:0]  memBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrLatch <= '0;
    else if (strobes.capture) addrLatch <= addr;
  end

  // contents deliberately not reset
  always_ff @(posedge clk) begin
    if (strobes.wrEn) memBits[addrLatch] <= dataIn;
  end

  assign dataOutEn = strobes.drive;
  assign dataOut   = strobes.drive ? memBits[addrLatch] : 1'b0;

endmodule

// File: rtl/latched_bit_ram.sv
module latched_bit_ram
  import latched_bit_ram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeN,
  input  logic              gateAN,
  input  logic              gateBN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn,
  output logic              selected
);

  ctrlStrobes_t strobes;

  lbr_ctrl #(.READ_LAT(READ_LAT)) ctrlI (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .gateAN(gateAN),
    .gateBN(gateBN), .writeN(writeN), .strobes(strobes), .selected(selected)
  );

  lbr_datapath #(.ADDR_W(ADDR_W)) dpI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

endmodule

// File: rtl/latched_bit_ram_chk.sv
module latched_bit_ram_chk (
  input logic clk,
  input logic rstN,
  input logic strobeN,
  input logic gateAN,
  input logic gateBN,
  input logic writeN,
  input logic dataOut,
  input logic dataOutEn,
  input logic selected
);

  // R9
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> !dataOut);

  // R8
  strobe_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeN |=> (!selected && !dataOutEn));

  // R5
  write_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeN |=> !dataOutEn);

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateAN || gateBN) |=> !dataOutEn);

  // R2
  fresh_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> ($past(strobeN) == 1'b0 && $past(strobeN, 2) == 1'b1));

  // R6
  drive_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> selected);

endmodule

bind latched_bit_ram latched_bit_ram_chk chkI (
  .clk(clk), .rstN(rstN), .strobeN(strobeN), .gateAN(gateAN), .gateBN(gateBN),
  .writeN(writeN), .dataOut(dataOut), .dataOutEn(dataOutEn), .selected(selected)
);

// File: tb/latched_bit_ram_test.sv
module latched_bit_ram_test;

  localparam int READ_LAT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strobeN = 1'b1;
  logic       gateAN = 1'b0;
  logic       gateBN = 1'b0;
  logic       writeN = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       dataIn = 1'b0;
  logic       dataOut, dataOutEn, selected;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  latched_bit_ram #(.ADDR_W(8), .READ_LAT(READ_LAT)) uut (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .gateAN(gateAN), .gateBN(gateBN),
    .writeN(writeN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .selected(selected)
  );

  always #5 clk = ~clk;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // strobe high for one edge, then low with the given address
  task automatic openAcc(input logic [7:0] a);
    strobeN = 1'b1;
    cyc(1);
    addr = a;
    strobeN = 1'b0;
    cyc(1);
  endtask

  task automatic closeAcc();
    strobeN = 1'b1;
    writeN = 1'b1;
    cyc(1);
  endtask

  task automatic writeBit(input logic [7:0] a, input logic d);
    writeN = 1'b0;
    dataIn = d;
    openAcc(a);
    chk("R2", "selected after opening edge", selected, 1'b1);
    cyc(1);
    chk("R5", "output off during write", dataOutEn, 1'b0);
    closeAcc();
  endtask

  task automatic readBit(input string req, input logic [7:0] a, input logic exp);
    writeN = 1'b1;
    openAcc(a);
    chk("R10", "output off at opening edge", dataOutEn, 1'b0);
    cyc(READ_LAT - 1);
    chk("R6", "output off one edge early", dataOutEn, 1'b0);
    cyc(1);
    chk("R6", "output enabled at latency", dataOutEn, 1'b1);
    chk(req, "read data", dataOut, exp);
  endtask

  task automatic testReset();
    chk("R1", "selected in reset", selected, 1'b0);
    chk("R1", "dataOutEn in reset", dataOutEn, 1'b0);
    chk("R1", "dataOut in reset", dataOut, 1'b0);
  endtask

  task automatic testWriteRead();
    writeBit(8'h00, 1'b1);
    writeBit(8'hFF, 1'b0);
    writeBit(8'h5A, 1'b1);
    writeBit(8'hA5, 1'b0);
    writeBit(8'h01, 1'b0);
    readBit("R4", 8'h00, 1'b1);
    closeAcc();
    readBit("R4", 8'hFF, 1'b0);
    closeAcc();
    readBit("R4", 8'h5A, 1'b1);
    closeAcc();
    readBit("R4", 8'hA5, 1'b0);
    closeAcc();
    writeBit(8'hFF, 1'b1);
    readBit("R4", 8'hFF, 1'b1);
    closeAcc();
  endtask

  task automatic testHeldLow();
    strobeN = 1'b0;
    writeN = 1'b0;
    dataIn = 1'b0;
    addr = 8'h5A;
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(4);
    chk("R2", "held-low strobe opens nothing", selected, 1'b0);
    chk("R2", "no output under held-low strobe", dataOutEn, 1'b0);
    writeN = 1'b1;
    closeAcc();
    readBit("R2", 8'h5A, 1'b1);
    closeAcc();
  endtask

  task automatic testAddrHold();
    // write to A while addr moves to B
    writeN = 1'b0;
    dataIn = 1'b0;
    openAcc(8'h00);
    addr = 8'h01;
    dataIn = 1'b0;
    cyc(2);
    closeAcc();
    readBit("R3", 8'h00, 1'b0);
    closeAcc();
    writeBit(8'h01, 1'b1);
    writeN = 1'b1;
    openAcc(8'h00);
    addr = 8'h01;
    cyc(READ_LAT);
    chk("R3", "read uses latched address", dataOut, 1'b0);
    addr = 8'hFF;
    cyc(1);
    chk("R3", "later address change ignored", dataOut, 1'b0);
    closeAcc();
  endtask

  task automatic testGates();
    readBit("R6", 8'h01, 1'b1);
    gateAN = 1'b1;
    cyc(1);
    chk("R7", "gate A turns output off", dataOutEn, 1'b0);
    chk("R7", "access still open with gate A", selected, 1'b1);
    chk("R9", "dataOut low when off", dataOut, 1'b0);
    gateAN = 1'b0;
    gateBN = 1'b1;
    cyc(1);
    chk("R7", "gate B turns output off", dataOutEn, 1'b0);
    gateBN = 1'b0;
    cyc(1);
    chk("R7", "output restored without strobe", dataOutEn, 1'b1);
    chk("R7", "restored data", dataOut, 1'b1);
    // write-enable low during open read
    writeN = 1'b0;
    dataIn = 1'b1;
    cyc(1);
    chk("R5", "write enable turns output off", dataOutEn, 1'b0);
    closeAcc();
    chk("R8", "strobe high closes access", selected, 1'b0);
    chk("R8", "output off after close", dataOutEn, 1'b0);
    // write with both gates high still stores
    gateAN = 1'b1;
    gateBN = 1'b1;
    writeBit(8'hA5, 1'b1);
    gateAN = 1'b0;
    gateBN = 1'b0;
    readBit("R4", 8'hA5, 1'b1);
    // re-strobe straight from an enabled read
    readBit("R10", 8'h00, 1'b0);
    closeAcc();
  endtask

  initial begin
    #2;
    testReset();
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    testWriteRead();
    testHeldLow();
    testAddrHold();
    testGates();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule